// File: doc/BRIEF.md
# Partial-Dirty Write-Back Controller

This block keeps the coherence state and a per-segment dirty mask for a small set of cache lines. Each 64-byte line is split into eight 8-byte segments. Local writes mark segments dirty, and the line moves between invalid, unique-clean, unique-dirty, unique-dirty-partial and unique-clean-empty as writes, clean-unique completions, snoop invalidations and evictions arrive.

When a dirty line is evicted, the controller issues one write-back request over a valid/ready handshake. The request carries the line index, the dirty mask, and a flag that marks a full-line write-back. The flag is set only when all eight segments are dirty; otherwise the request is a partial write-back that carries only the dirty segments. A clean line is simply dropped.

A power-down request stalls local writes and drains every dirty line, lowest index first, before the acknowledge is raised. A lookup port exposes the state and mask of one line to the surrounding cache logic.

Top module: `pdwb_ctrl`

## Requirements
- R1: After an asynchronous reset, every line reads state 0 (invalid) with a zero mask. After reset wb_valid and pd_ack are low. Lookup state codes are: 0 invalid, 1 unique-clean, 2 unique-dirty, 3 unique-dirty-partial, 4 unique-clean-empty.
- R2: A clean-unique request marks a line pending, and its completion sets the line to state 1. If a snoop invalidation hits the line while the request is pending, the completion sets state 4 with a zero mask.
- R3: A write to a line in state 1, 2, 3 or 4 ORs wr_mask into the line's mask, where bit i covers bytes 8i to 8i+7. An all-ones result gives state 2, and any other non-zero result gives state 3. A write to an invalid line is ignored.
- R4: Evicting a line in state 1 or 4 issues no write-back, and the line reads state 0 on the next cycle.
- R5: Evicting a line whose mask is all ones raises wb_valid with wb_full=1 and wb_mask=8'hFF.
- R6: Evicting a line with some but not all segments dirty raises wb_valid with wb_full=0 and wb_mask equal to its dirty mask.
- R7: wb_idx, wb_mask and wb_full stay stable while wb_valid is high and wb_ready is low. Only one write-back is outstanding at a time: evict_ready stays low from launch until wb_ack.
- R8: A wb_ack received after the request was accepted returns the line to state 0 with a zero mask.
- R9: While pd_req is high, wr_stall is high and writes have no effect. Dirty lines are written back in ascending index order. pd_ack rises only once no line is dirty and no write-back is in progress.
- R10: A snoop invalidation sets a line to state 0 and clears its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cu_req_valid | input | 1 | Clean-unique request issued for cu_req_idx |
| cu_req_idx | input | 2 | Line of the clean-unique request |
| cu_done_valid | input | 1 | Clean-unique completion for cu_done_idx |
| cu_done_idx | input | 2 | Line of the completion |
| snp_valid | input | 1 | Snoop invalidation for snp_idx |
| snp_idx | input | 2 | Line to invalidate |
| wr_valid | input | 1 | Local write strobe |
| wr_idx | input | 2 | Line written |
| wr_mask | input | 8 | Segments written, one bit per 8 bytes |
| wr_stall | output | 1 | Write is not taken this cycle |
| evict_valid | input | 1 | Eviction request |
| evict_idx | input | 2 | Line to evict |
| evict_ready | output | 1 | Eviction accepted this cycle |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request accepted |
| wb_idx | output | 2 | Line being written back |
| wb_mask | output | 8 | Segments carried by the write-back |
| wb_full | output | 1 | Full-line write-back (1) or partial (0) |
| wb_ack | input | 1 | Write-back completed |
| pd_req | input | 1 | Power-down request |
| pd_ack | output | 1 | All dirty data drained |
| lk_idx | input | 2 | Line to look up |
| lk_state | output | 3 | State code of the looked-up line |
| lk_mask | output | 8 | Dirty mask of the looked-up line |

## Verification
The eviction path is driven with write-mask sequences that leave a line clean, with a single segment dirty, with all segments dirty in one write, with all segments dirty across two complementary writes, and with a scattered pattern merged from two writes. These patterns separate a full-line write-back from a partial one, show that masks accumulate by OR and not by replacement, and show that a clean line produces no request. Directed cases cover a snoop during an outstanding clean-unique request, a write to an invalid line, a snoop on a dirty line, and a power-down with two dirty lines out of order plus a stalled write. Together these show the ascending drain order and that pd_ack waits for the last acknowledge.

// File: rtl/pdwb_pkg.sv
package pdwb_pkg;
  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_UC  = 3'd1,
    ST_UD  = 3'd2,
    ST_UDP = 3'd3,
    ST_UCE = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    E_IDLE = 2'd0,
    E_REQ  = 2'd1,
    E_WAIT = 2'd2
  } eng_st_t;
endpackage

// File: rtl/pdwb_line_table.sv
module pdwb_line_table
  import pdwb_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SEG_COUNT = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cu_req_valid,
  input  logic [IDX_W-1:0]                     cu_req_idx,
  input  logic                                 cu_done_valid,
  input  logic [IDX_W-1:0]                     cu_done_idx,
  input  logic                                 snp_valid,
  input  logic [IDX_W-1:0]                     snp_idx,
  input  logic                                 wr_fire,
  input  logic [IDX_W-1:0]                     wr_idx,
  input  logic [SEG_COUNT-1:0]                 wr_mask,
  input  logic                                 inv_valid,
  input  logic [IDX_W-1:0]                     inv_idx,
  input  logic [IDX_W-1:0]                     lk_idx,
  output logic [2:0]                           lk_state,
  output logic [SEG_COUNT-1:0]                 lk_mask,
  output logic [NUM_LINES-1:0]                 dirty_vec,
  output logic [NUM_LINES-1:0][SEG_COUNT-1:0]  mask_vec
);
  line_st_t st_q [NUM_LINES];

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    line_st_t             st_n;
    logic [SEG_COUNT-1:0] m_q, m_n, merged;
    logic                 pend_q, pend_n, lost_q, lost_n;
    logic                 req_hit, done_hit, snp_hit, wr_hit, inv_hit;

    always_comb begin
      req_hit  = cu_req_valid  && (cu_req_idx  == IDX_W'(gi));
      done_hit = cu_done_valid && (cu_done_idx == IDX_W'(gi));
      snp_hit  = snp_valid     && (snp_idx     == IDX_W'(gi));
      wr_hit   = wr_fire       && (wr_idx      == IDX_W'(gi));
      inv_hit  = inv_valid     && (inv_idx     == IDX_W'(gi));
      merged   = m_q | wr_mask;
      st_n     = st_q[gi];
      m_n      = m_q;
      pend_n   = pend_q;
      lost_n   = lost_q;
      if (req_hit) begin
        pend_n = 1'b1;
        lost_n = 1'b0;
      end
      if (inv_hit) begin
        st_n = ST_INV;
        m_n  = '0;
      end else if (done_hit && pend_q) begin
        st_n   = (lost_q || snp_hit) ? ST_UCE : ST_UC;
        m_n    = '0;
        pend_n = 1'b0;
        lost_n = 1'b0;
      end else if (snp_hit) begin
        st_n = ST_INV;
        m_n  = '0;
        if (pend_q) lost_n = 1'b1;
      end else if (wr_hit && (st_q[gi] != ST_INV) && (wr_mask != '0)) begin
        m_n  = merged;
        st_n = (&merged) ? ST_UD : ST_UDP;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[gi] <= ST_INV;
        m_q      <= '0;
        pend_q   <= 1'b0;
        lost_q   <= 1'b0;
      end else begin
        st_q[gi] <= st_n;
        m_q      <= m_n;
        pend_q   <= pend_n;
        lost_q   <= lost_n;
      end
    end

    assign dirty_vec[gi] = (st_q[gi] == ST_UD) || (st_q[gi] == ST_UDP);
    assign mask_vec[gi]  = m_q;

    // R3: state code and dirty mask always agree
    assert_line_consistent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q[gi] == ST_UD)  -> (&m_q)) &&
      ((st_q[gi] == ST_UDP) -> ((m_q != '0) && !(&m_q))) &&
      (((st_q[gi] == ST_INV) || (st_q[gi] == ST_UC) || (st_q[gi] == ST_UCE)) -> (m_q == '0)));

    // R4 / R8: an invalidate from the engine leaves the line empty
    assert_evict_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inv_hit |=> (st_q[gi] == ST_INV) && (m_q == '0));
  end

  assign lk_state = st_q[lk_idx];
  assign lk_mask  = mask_vec[lk_idx];
endmodule

// File: rtl/pdwb_wb_engine.sv
module pdwb_wb_engine
  import pdwb_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SEG_COUNT = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 evict_valid,
  input  logic [IDX_W-1:0]                     evict_idx,
  output logic                                 evict_ready,
  input  logic                                 wr_valid,
  input  logic [IDX_W-1:0]                     wr_idx,
  output logic                                 wr_stall,
  output logic                                 wr_fire,
  input  logic                                 pd_req,
  output logic                                 pd_ack,
  input  logic [NUM_LINES-1:0]                 dirty_vec,
  input  logic [NUM_LINES-1:0][SEG_COUNT-1:0]  mask_vec,
  output logic                                 inv_valid,
  output logic [IDX_W-1:0]                     inv_idx,
  output logic                                 wb_valid,
  input  logic                                 wb_ready,
  output logic [IDX_W-1:0]                     wb_idx,
  output logic [SEG_COUNT-1:0]                 wb_mask,
  output logic                                 wb_full,
  input  logic                                 wb_ack
);
  eng_st_t              st_q, st_n;
  logic [IDX_W-1:0]     cur_q, cur_n, first_idx, launch_idx;
  logic [SEG_COUNT-1:0] msk_q, msk_n;
  logic                 idle, any_dirty, evict_fire, ev_dirty, launch;

  always_comb begin
    idle      = (st_q == E_IDLE);
    any_dirty = |dirty_vec;
    first_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (dirty_vec[i]) first_idx = IDX_W'(i);
    end
    wr_stall    = pd_req || (!idle && (wr_idx == cur_q));
    wr_fire     = wr_valid && !wr_stall;
    evict_ready = idle && !pd_req && !(wr_fire && (wr_idx == evict_idx));
    evict_fire  = evict_valid && evict_ready;
    ev_dirty    = dirty_vec[evict_idx];
    launch      = idle && (pd_req ? any_dirty : (evict_fire && ev_dirty));
    launch_idx  = pd_req ? first_idx : evict_idx;
    inv_valid   = (evict_fire && !ev_dirty) || ((st_q == E_WAIT) && wb_ack);
    inv_idx     = (st_q == E_WAIT) ? cur_q : evict_idx;
    pd_ack      = pd_req && idle && !any_dirty;

    st_n  = st_q;
    cur_n = cur_q;
    msk_n = msk_q;
    case (st_q)
      E_IDLE: if (launch) begin
        st_n  = E_REQ;
        cur_n = launch_idx;
        msk_n = mask_vec[launch_idx];
      end
      E_REQ:  if (wb_ready) st_n = E_WAIT;
      E_WAIT: if (wb_ack)   st_n = E_IDLE;
      default: st_n = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= E_IDLE;
      cur_q <= '0;
      msk_q <= '0;
    end else begin
      st_q  <= st_n;
      cur_q <= cur_n;
      msk_q <= msk_n;
    end
  end

  assign wb_valid = (st_q == E_REQ);
  assign wb_idx   = cur_q;
  assign wb_mask  = msk_q;
  assign wb_full  = &msk_q;

  // R7: request fields hold until the handshake completes
  assert_wb_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> wb_valid && $stable(wb_idx) && $stable(wb_mask) && $stable(wb_full));

  // R9: acknowledge only when no dirty data remains in the table
  assert_pdack_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack |-> (dirty_vec == '0));

  // R9: acknowledge never overlaps a pending write-back request
  assert_pdack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack |-> !wb_valid);

  // R7: nothing new is accepted while a write-back is outstanding
  assert_single_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !evict_ready);
endmodule

// File: rtl/pdwb_ctrl.sv
module pdwb_ctrl
  import pdwb_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SEG_COUNT = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cu_req_valid,
  input  logic [IDX_W-1:0]     cu_req_idx,
  input  logic                 cu_done_valid,
  input  logic [IDX_W-1:0]     cu_done_idx,
  input  logic                 snp_valid,
  input  logic [IDX_W-1:0]     snp_idx,
  input  logic                 wr_valid,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [SEG_COUNT-1:0] wr_mask,
  output logic                 wr_stall,
  input  logic                 evict_valid,
  input  logic [IDX_W-1:0]     evict_idx,
  output logic                 evict_ready,
  output logic                 wb_valid,
  input  logic                 wb_ready,
  output logic [IDX_W-1:0]     wb_idx,
  output logic [SEG_COUNT-1:0] wb_mask,
  output logic                 wb_full,
  input  logic                 wb_ack,
  input  logic                 pd_req,
  output logic                 pd_ack,
  input  logic [IDX_W-1:0]     lk_idx,
  output logic [2:0]           lk_state,
  output logic [SEG_COUNT-1:0] lk_mask
);
  logic                                wr_fire, inv_valid;
  logic [IDX_W-1:0]                    inv_idx;
  logic [NUM_LINES-1:0]                dirty_vec;
  logic [NUM_LINES-1:0][SEG_COUNT-1:0] mask_vec;

  pdwb_line_table #(.NUM_LINES(NUM_LINES), .SEG_COUNT(SEG_COUNT)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cu_req_valid(cu_req_valid), .cu_req_idx(cu_req_idx),
    .cu_done_valid(cu_done_valid), .cu_done_idx(cu_done_idx),
    .snp_valid(snp_valid), .snp_idx(snp_idx),
    .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .inv_valid(inv_valid), .inv_idx(inv_idx),
    .lk_idx(lk_idx), .lk_state(lk_state), .lk_mask(lk_mask),
    .dirty_vec(dirty_vec), .mask_vec(mask_vec)
  );

  pdwb_wb_engine #(.NUM_LINES(NUM_LINES), .SEG_COUNT(SEG_COUNT)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_idx(evict_idx), .evict_ready(evict_ready),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_stall(wr_stall), .wr_fire(wr_fire),
    .pd_req(pd_req), .pd_ack(pd_ack),
    .dirty_vec(dirty_vec), .mask_vec(mask_vec),
    .inv_valid(inv_valid), .inv_idx(inv_idx),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx),
    .wb_mask(wb_mask), .wb_full(wb_full), .wb_ack(wb_ack)
  );
endmodule

// File: tb/pdwb_ctrl_bench.sv
`timescale 1ns/1ps
module pdwb_ctrl_bench;
  logic       clk, rst_n;
  logic       cu_req_valid, cu_done_valid, snp_valid, wr_valid, evict_valid;
  logic [1:0] cu_req_idx, cu_done_idx, snp_idx, wr_idx, evict_idx, lk_idx, wb_idx;
  logic [7:0] wr_mask, wb_mask, lk_mask;
  logic       wr_stall, evict_ready, wb_valid, wb_ready, wb_full, wb_ack, pd_req, pd_ack;
  logic [2:0] lk_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  pdwb_ctrl u_pdwb_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cu_req_valid(cu_req_valid), .cu_req_idx(cu_req_idx),
    .cu_done_valid(cu_done_valid), .cu_done_idx(cu_done_idx),
    .snp_valid(snp_valid), .snp_idx(snp_idx),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_stall(wr_stall),
    .evict_valid(evict_valid), .evict_idx(evict_idx), .evict_ready(evict_ready),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx), .wb_mask(wb_mask),
    .wb_full(wb_full), .wb_ack(wb_ack),
    .pd_req(pd_req), .pd_ack(pd_ack),
    .lk_idx(lk_idx), .lk_state(lk_state), .lk_mask(lk_mask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {first write mask, second write mask, expect write-back, expect full, expected mask}
  localparam logic [25:0] VEC [6] = '{
    {8'h00, 8'h00, 1'b0, 1'b0, 8'h00},
    {8'h01, 8'h00, 1'b1, 1'b0, 8'h01},
    {8'hFF, 8'h00, 1'b1, 1'b1, 8'hFF},
    {8'h0F, 8'hF0, 1'b1, 1'b1, 8'hFF},
    {8'h81, 8'h03, 1'b1, 1'b0, 8'h83},
    {8'h00, 8'h40, 1'b1, 1'b0, 8'h40}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [1:0] idx, input int exp_st, input int exp_m, input string req);
    lk_idx = idx;
    #1;
    chk(lk_state == 3'(exp_st), req, int'(lk_state), exp_st);
    chk(lk_mask == 8'(exp_m), req, int'(lk_mask), exp_m);
  endtask

  task automatic acquire(input logic [1:0] idx, input bit lose);
    cu_req_valid = 1'b1; cu_req_idx = idx; tick(); cu_req_valid = 1'b0;
    if (lose) begin
      snp_valid = 1'b1; snp_idx = idx; tick(); snp_valid = 1'b0;
    end
    cu_done_valid = 1'b1; cu_done_idx = idx; tick(); cu_done_valid = 1'b0;
  endtask

  task automatic write(input logic [1:0] idx, input logic [7:0] m);
    wr_valid = 1'b1; wr_idx = idx; wr_mask = m; tick(); wr_valid = 1'b0;
  endtask

  task automatic finish_wb();
    wb_ready = 1'b1; tick(); wb_ready = 1'b0;
    wb_ack = 1'b1; tick(); wb_ack = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cu_req_valid = 0; cu_done_valid = 0; snp_valid = 0; wr_valid = 0; evict_valid = 0;
    cu_req_idx = 0; cu_done_idx = 0; snp_idx = 0; wr_idx = 0; evict_idx = 0; lk_idx = 0;
    wr_mask = 0; wb_ready = 0; wb_ack = 0; pd_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 4; i++) look(2'(i), 0, 0, "R1 reset line");
    chk(!wb_valid, "R1 wb_valid", int'(wb_valid), 0);
    chk(!pd_ack, "R1 pd_ack", int'(pd_ack), 0);

    // Main vectors: R3, R4, R5, R6, R7, R8
    foreach (VEC[v]) begin
      logic [7:0] w1, w2, em;
      logic       ewb, efull;
      int         est;
      {w1, w2, ewb, efull, em} = VEC[v];
      acquire(2'd2, 1'b0);
      look(2'd2, 1, 0, "R2 clean-unique done");
      if (w1 != 0) write(2'd2, w1);
      if (w2 != 0) write(2'd2, w2);
      est = (em == 8'h00) ? 1 : ((em == 8'hFF) ? 2 : 3);
      look(2'd2, est, int'(em), "R3 merged state");
      evict_valid = 1'b1; evict_idx = 2'd2;
      #1;
      chk(evict_ready, "R7 evict_ready idle", int'(evict_ready), 1);
      tick(); evict_valid = 1'b0;
      chk(wb_valid == ewb, ewb ? "R5 wb_valid" : "R4 no write-back", int'(wb_valid), int'(ewb));
      if (ewb) begin
        chk(wb_full == efull, efull ? "R5 wb_full" : "R6 wb_full", int'(wb_full), int'(efull));
        chk(wb_mask == em, efull ? "R5 wb_mask" : "R6 wb_mask", int'(wb_mask), int'(em));
        chk(wb_idx == 2'd2, "R6 wb_idx", int'(wb_idx), 2);
        tick();
        chk(wb_valid && wb_mask == em && wb_idx == 2'd2, "R7 stable while not ready",
            int'(wb_mask), int'(em));
        evict_valid = 1'b1; evict_idx = 2'd0; #1;
        chk(!evict_ready, "R7 single outstanding", int'(evict_ready), 0);
        evict_valid = 1'b0;
        finish_wb();
        look(2'd2, 0, 0, "R8 after ack");
      end else begin
        look(2'd2, 0, 0, "R4 clean evict");
      end
    end

    // R2: snoop during pending clean-unique gives unique-clean-empty
    acquire(2'd1, 1'b1);
    look(2'd1, 4, 0, "R2 unique-clean-empty");
    write(2'd1, 8'h0F);
    look(2'd1, 3, 8'h0F, "R3 write on empty line");
    // R10: snoop on dirty line
    snp_valid = 1'b1; snp_idx = 2'd1; tick(); snp_valid = 1'b0;
    look(2'd1, 0, 0, "R10 snoop invalidate");
    // R3: write to invalid line ignored
    write(2'd3, 8'hFF);
    look(2'd3, 0, 0, "R3 write to invalid");
    // R4: evict unique-clean-empty line
    acquire(2'd0, 1'b1);
    evict_valid = 1'b1; evict_idx = 2'd0; tick(); evict_valid = 1'b0;
    chk(!wb_valid, "R4 empty evict no wb", int'(wb_valid), 0);
    look(2'd0, 0, 0, "R4 empty evict");

    // R9: power-down drain with lines 3 (partial) and 1 (full) dirty
    acquire(2'd0, 1'b0);
    acquire(2'd3, 1'b0); write(2'd3, 8'h24);
    acquire(2'd1, 1'b0); write(2'd1, 8'hFF);
    pd_req = 1'b1;
    wr_valid = 1'b1; wr_idx = 2'd0; wr_mask = 8'h01;
    #1;
    chk(wr_stall, "R9 wr_stall", int'(wr_stall), 1);
    chk(!pd_ack, "R9 pd_ack early", int'(pd_ack), 0);
    tick(); wr_valid = 1'b0;
    chk(wb_valid && wb_idx == 2'd1, "R9 drain first idx", int'(wb_idx), 1);
    chk(wb_full && wb_mask == 8'hFF, "R9 drain full", int'(wb_mask), 8'hFF);
    finish_wb();
    chk(!pd_ack, "R9 pd_ack mid drain", int'(pd_ack), 0);
    tick();
    chk(wb_valid && wb_idx == 2'd3, "R9 drain second idx", int'(wb_idx), 3);
    chk(!wb_full && wb_mask == 8'h24, "R9 drain partial", int'(wb_mask), 8'h24);
    finish_wb();
    chk(pd_ack, "R9 pd_ack after drain", int'(pd_ack), 1);
    look(2'd0, 1, 0, "R9 stalled write no effect");
    pd_req = 1'b0; #1;
    chk(!pd_ack, "R9 pd_ack release", int'(pd_ack), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule